// File: doc/BRIEF.md
# Word and Bit Clock Phase-Lock Monitor

This block runs on the master clock and keeps two internal phase counters in step with an external word clock and an external bit clock. After a hardware reset or a soft reset it waits for the first rising edge of the word clock and takes that edge as the word boundary. It then waits for the first falling edge of the bit clock and takes that edge as the bit boundary. From then on every observed edge is compared with the position the counters predict. An edge is accepted from two master clocks early to one master clock late. An edge outside that span, or no edge at all by the end of it, is a sync error.

The block produces a one-cycle word boundary strobe, a one-cycle bit boundary strobe and a lock flag. The lock flag rises only after two consecutive word periods are confirmed good, and both clocks must have been verified in each of those periods. It drops on the clock after any error. An error also raises a one-cycle resync strobe, and the block then returns by itself to the alignment search. Both external clocks pass through two-flop synchronizers. Every timing statement below counts from the cycle in which a synchronized edge is detected, which is two master clocks after the input changes.

Top module: `fsbck_sync_monitor`

## Requirements
- R1: The word period is 1024 master clocks when `mclk_ratio_hi` is 0 and 1280 when it is 1. Once aligned, `word_tick` pulses for one cycle per word period. The pulse falls two master clocks after each on-time rising edge of `word_clk`.
- R2: The bit period is the word period divided by 128 when `fast_rate` is 1 and by 64 when it is 0. Once aligned, `bit_tick` pulses for one cycle per bit period. The pulse falls two master clocks after each on-time falling edge of `bit_clk`.
- R3: After reset, `word_tick` and `bit_tick` stay low until a rising edge of `word_clk` has been seen. The bit boundary is then taken from the first falling edge of `bit_clk` that follows.
- R4: A `word_clk` rising edge that arrives up to 2 master clocks early or up to 1 master clock late is accepted. `sync_ok` stays high.
- R5: A `word_clk` rising edge that arrives 3 master clocks early is an error. One clock after the edge is detected, `sync_ok` is low and `resync_pulse` is high.
- R6: If no `word_clk` rising edge has arrived by the last accepted position (one clock after the predicted one), that is an error. `sync_ok` falls and `resync_pulse` pulses in the following clock.
- R7: `bit_clk` falling edges are checked against the same window. An edge 2 master clocks early is accepted. An edge 3 early drops `sync_ok` one clock after it is detected.
- R8: `sync_ok` is low during reset. It rises two clocks after the second `word_tick` that follows alignment, once two complete word windows have closed without error.
- R9: A one-cycle `soft_rst` clears `sync_ok`, `word_tick` and `bit_tick` on the next clock. It raises no `resync_pulse`, and alignment then restarts as in R3 and R8.
- R10: After an error the block realigns by itself and regains `sync_ok` by the sequence of R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| soft_rst | input | 1 | Synchronous restart request, active high |
| mclk_ratio_hi | input | 1 | Strap: 1 selects the 1280-clock word, 0 the 1024-clock word |
| fast_rate | input | 1 | Strap: 1 selects 128 bits per word, 0 selects 64 |
| word_clk | input | 1 | External word clock, asynchronous |
| bit_clk | input | 1 | External bit clock, asynchronous |
| word_tick | output | 1 | One-cycle word boundary strobe |
| bit_tick | output | 1 | One-cycle bit boundary strobe |
| sync_ok | output | 1 | Lock flag |
| resync_pulse | output | 1 | One-cycle strobe on each sync error |

## Verification
Steady clocks in all four strap combinations confirm the strobe periods and their fixed phase to the input edges, which separates a wrong divider from a wrong alignment edge. Word edges displaced by −2 and +1 clocks probe the inside edges of the window, and a −3 displacement probes the outside. A stopped word clock tells the missing-edge path apart from the misplaced-edge path. Bit clock displacements of −2 and −3 cover the second tracker. A quiet word clock at start-up shows that nothing happens before the first rising edge. A soft reset while locked shows that it clears the lock without being reported as an error.

// File: rtl/fsync_pkg.sv
package fsync_pkg;
  typedef enum logic [1:0] {
    SEEK_WORD = 2'd0,
    SEEK_BIT  = 2'd1,
    TRACKING  = 2'd2
  } sync_state_e;
endpackage

// File: rtl/fsbck_edge_det.sv
module fsbck_edge_det #(
  parameter int STAGES  = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);
  // Reset to the idle level of the watched edge so no false edge appears.
  localparam logic IDLE = ~FALLING;

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q;

  always_comb chain_d = {chain_q[STAGES-2:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{IDLE}};
      last_q  <= IDLE;
    end else begin
      chain_q <= chain_d;
      last_q  <= chain_q[STAGES-1];
    end
  end

  generate
    if (FALLING) begin : g_fall
      assign edge_o = last_q & ~chain_q[STAGES-1];
    end else begin : g_rise
      assign edge_o = chain_q[STAGES-1] & ~last_q;
    end
  endgenerate
endmodule

// File: rtl/fsbck_phase_tracker.sv
module fsbck_phase_tracker #(
  parameter int CNT_W = 11,
  parameter int EARLY = 2,
  parameter int LATE  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             align_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             bound_o,
  output logic             close_o,
  output logic             err_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             armed_q, armed_d;
  logic             in_win, at_close;

  always_comb begin
    in_win   = (cnt_q >= period_i - CNT_W'(EARLY)) || (cnt_q <= CNT_W'(LATE));
    at_close = (cnt_q == CNT_W'(LATE));
    err_o    = armed_q & ((edge_i & (~in_win | seen_q)) |
                          (at_close & ~seen_q & ~edge_i));
    bound_o  = armed_q & (cnt_q == '0);
    close_o  = armed_q & at_close;
  end

  always_comb begin
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    armed_d = armed_q;
    if (clr_i) begin
      armed_d = 1'b0;
      cnt_d   = '0;
      seen_d  = 1'b0;
    end else if (align_i) begin
      // The aligning edge defines position 0; the next cycle is position 1.
      armed_d = 1'b1;
      cnt_d   = CNT_W'(1);
      seen_d  = (LATE > 0);
    end else if (armed_q) begin
      cnt_d = (cnt_q == period_i - CNT_W'(1)) ? '0 : cnt_q + CNT_W'(1);
      if (at_close)
        seen_d = 1'b0;
      else if (edge_i && in_win)
        seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/fsbck_lock_ctrl.sv
module fsbck_lock_ctrl
  import fsync_pkg::*;
#(
  parameter int LOCK_WORDS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic fs_rise,
  input  logic bck_fall,
  input  logic w_err,
  input  logic b_err,
  input  logic w_close,
  input  logic b_close,
  output logic w_align,
  output logic b_align,
  output logic trk_clr,
  output logic sync_ok,
  output logic resync_pulse
);
  localparam int GOOD_W = $clog2(LOCK_WORDS + 1);

  sync_state_e       state_q, state_d;
  logic [GOOD_W-1:0] good_q, good_d;
  logic              bit_ok_q, bit_ok_d;
  logic              ok_q, ok_d;
  logic              rsy_q, rsy_d;
  logic              err_any, restart, word_good;

  always_comb begin
    err_any   = ((state_q == SEEK_BIT) & w_err) |
                ((state_q == TRACKING) & (w_err | b_err));
    restart   = soft_rst | err_any;
    trk_clr   = restart;
    w_align   = (state_q == SEEK_WORD) & fs_rise & ~soft_rst;
    b_align   = (state_q == SEEK_BIT) & bck_fall & ~restart;
    word_good = (state_q == TRACKING) & w_close & (bit_ok_q | b_close);

    state_d = state_q;
    if (restart)
      state_d = SEEK_WORD;
    else if (w_align)
      state_d = SEEK_BIT;
    else if (b_align)
      state_d = TRACKING;

    good_d = good_q;
    if (restart || state_q != TRACKING)
      good_d = '0;
    else if (word_good && good_q != GOOD_W'(LOCK_WORDS))
      good_d = good_q + GOOD_W'(1);

    bit_ok_d = bit_ok_q;
    if (restart || state_q != TRACKING || w_close)
      bit_ok_d = 1'b0;
    else if (b_close)
      bit_ok_d = 1'b1;

    ok_d = ok_q;
    if (restart)
      ok_d = 1'b0;
    else if (word_good && good_q == GOOD_W'(LOCK_WORDS - 1))
      ok_d = 1'b1;

    rsy_d = err_any & ~soft_rst;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SEEK_WORD;
      good_q   <= '0;
      bit_ok_q <= 1'b0;
      ok_q     <= 1'b0;
      rsy_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      good_q   <= good_d;
      bit_ok_q <= bit_ok_d;
      ok_q     <= ok_d;
      rsy_q    <= rsy_d;
    end
  end

  assign sync_ok      = ok_q;
  assign resync_pulse = rsy_q;
endmodule

// File: rtl/fsbck_sync_monitor.sv
module fsbck_sync_monitor #(
  parameter int WORD_LEN_STD = 1024,
  parameter int WORD_LEN_ALT = 1280,
  parameter int BITS_FAST    = 128,
  parameter int BITS_SLOW    = 64,
  parameter int WIN_EARLY    = 2,
  parameter int WIN_LATE     = 1,
  parameter int LOCK_WORDS   = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic mclk_ratio_hi,
  input  logic fast_rate,
  input  logic word_clk,
  input  logic bit_clk,
  output logic word_tick,
  output logic bit_tick,
  output logic sync_ok,
  output logic resync_pulse
);
  localparam int WORD_MAX = (WORD_LEN_ALT > WORD_LEN_STD) ? WORD_LEN_ALT : WORD_LEN_STD;
  localparam int CNT_W    = $clog2(WORD_MAX + 1);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  // Index 0: word clock rising edge, index 1: bit clock falling edge.
  logic [1:0] raw_clk, clk_edge;
  assign raw_clk = {bit_clk, word_clk};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_edge
      fsbck_edge_det #(
        .STAGES (SYNC_STAGES),
        .FALLING(g == 1)
      ) u_det (
        .clk   (clk),
        .rst_n (rst_sync_n),
        .din   (raw_clk[g]),
        .edge_o(clk_edge[g])
      );
    end
  endgenerate

  logic [CNT_W-1:0] word_len, bit_len;
  always_comb begin
    word_len = mclk_ratio_hi ? CNT_W'(WORD_LEN_ALT) : CNT_W'(WORD_LEN_STD);
    bit_len  = fast_rate ? CNT_W'(word_len / CNT_W'(BITS_FAST))
                         : CNT_W'(word_len / CNT_W'(BITS_SLOW));
  end

  logic trk_clr, w_align, b_align;
  logic w_bound, w_close, w_err;
  logic b_bound, b_close, b_err;

  fsbck_phase_tracker #(.CNT_W(CNT_W), .EARLY(WIN_EARLY), .LATE(WIN_LATE)) u_word (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (trk_clr),
    .align_i (w_align),
    .edge_i  (clk_edge[0]),
    .period_i(word_len),
    .bound_o (w_bound),
    .close_o (w_close),
    .err_o   (w_err)
  );

  fsbck_phase_tracker #(.CNT_W(CNT_W), .EARLY(WIN_EARLY), .LATE(WIN_LATE)) u_bit (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .clr_i   (trk_clr),
    .align_i (b_align),
    .edge_i  (clk_edge[1]),
    .period_i(bit_len),
    .bound_o (b_bound),
    .close_o (b_close),
    .err_o   (b_err)
  );

  fsbck_lock_ctrl #(.LOCK_WORDS(LOCK_WORDS)) u_lock (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .soft_rst    (soft_rst),
    .fs_rise     (clk_edge[0]),
    .bck_fall    (clk_edge[1]),
    .w_err       (w_err),
    .b_err       (b_err),
    .w_close     (w_close),
    .b_close     (b_close),
    .w_align     (w_align),
    .b_align     (b_align),
    .trk_clr     (trk_clr),
    .sync_ok     (sync_ok),
    .resync_pulse(resync_pulse)
  );

  assign word_tick = w_bound;
  assign bit_tick  = b_bound;
endmodule

// File: rtl/fsbck_sync_chk.sv
module fsbck_sync_chk #(
  parameter int WORD_LEN_STD = 1024,
  parameter int WORD_LEN_ALT = 1280,
  parameter int BITS_FAST    = 128,
  parameter int BITS_SLOW    = 64
) (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic mclk_ratio_hi,
  input logic fast_rate,
  input logic word_tick,
  input logic bit_tick,
  input logic sync_ok,
  input logic resync_pulse
);
  logic [15:0] wgap_q, bgap_q, exp_w, exp_b;
  logic        wvalid_q, bvalid_q;

  always_comb begin
    exp_w = mclk_ratio_hi ? 16'(WORD_LEN_ALT) : 16'(WORD_LEN_STD);
    exp_b = fast_rate ? 16'(exp_w / 16'(BITS_FAST)) : 16'(exp_w / 16'(BITS_SLOW));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgap_q <= '0; bgap_q <= '0; wvalid_q <= 1'b0; bvalid_q <= 1'b0;
    end else begin
      wgap_q <= word_tick ? 16'd1 : ((wgap_q == 16'hFFFF) ? wgap_q : wgap_q + 16'd1);
      bgap_q <= bit_tick  ? 16'd1 : ((bgap_q == 16'hFFFF) ? bgap_q : bgap_q + 16'd1);
      if (soft_rst)          wvalid_q <= 1'b0;
      else if (word_tick)    wvalid_q <= 1'b1;
      else if (resync_pulse) wvalid_q <= 1'b0;
      if (soft_rst)          bvalid_q <= 1'b0;
      else if (bit_tick)     bvalid_q <= 1'b1;
      else if (resync_pulse) bvalid_q <= 1'b0;
    end
  end

  // R1
  word_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_tick && wvalid_q) |-> (wgap_q == exp_w));
  // R2
  bit_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && bvalid_q) |-> (bgap_q == exp_b));
  // R8
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_ok) |-> $past(word_tick, 2));
  // R5
  resync_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> !sync_ok);
  // R5
  lock_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_ok) |-> (resync_pulse || $past(soft_rst)));
  // R9
  soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!sync_ok && !word_tick && !bit_tick && !resync_pulse));
endmodule

bind fsbck_sync_monitor fsbck_sync_chk #(
  .WORD_LEN_STD(WORD_LEN_STD),
  .WORD_LEN_ALT(WORD_LEN_ALT),
  .BITS_FAST   (BITS_FAST),
  .BITS_SLOW   (BITS_SLOW)
) u_sync_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .soft_rst     (soft_rst),
  .mclk_ratio_hi(mclk_ratio_hi),
  .fast_rate    (fast_rate),
  .word_tick    (word_tick),
  .bit_tick     (bit_tick),
  .sync_ok      (sync_ok),
  .resync_pulse (resync_pulse)
);

// File: tb/test_fsbck_sync_monitor.sv
module test_fsbck_sync_monitor;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic mclk_ratio_hi = 1'b0;
  logic fast_rate = 1'b1;
  logic word_clk = 1'b0;
  logic bit_clk = 1'b0;
  logic word_tick, bit_tick, sync_ok, resync_pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int mc = 0;
  int foff = 0;
  int boff = 0;
  int fph = 0;
  int bph = 0;
  int P = 1024;
  int B = 8;
  bit fs_stop = 1'b0;
  bit finished = 1'b0;

  fsbck_sync_monitor i_fsbck_sync_monitor (
    .clk          (clk),
    .rst_n        (rst_n),
    .soft_rst     (soft_rst),
    .mclk_ratio_hi(mclk_ratio_hi),
    .fast_rate    (fast_rate),
    .word_clk     (word_clk),
    .bit_clk      (bit_clk),
    .word_tick    (word_tick),
    .bit_tick     (bit_tick),
    .sync_ok      (sync_ok),
    .resync_pulse (resync_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // External clock model: phase counters advanced on each falling master edge.
  always @(negedge clk) begin
    mc  = mc + 1;
    fph = (mc + foff) % P;
    bph = (mc + boff) % B;
    word_clk <= fs_stop ? 1'b0 : (fph < P/2);
    bit_clk  <= (bph < B/2);
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit cond, string req, int act, int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  task automatic wait_fph(int p);
    for (int i = 0; i < 4 * P; i++) begin
      tick();
      if (fph == p) break;
    end
  endtask

  task automatic wait_bph(int p);
    for (int i = 0; i < 4 * B; i++) begin
      tick();
      if (bph == p) break;
    end
  endtask

  task automatic do_reset(bit ratio_hi, bit fast);
    rst_n = 1'b0;
    soft_rst = 1'b0;
    mclk_ratio_hi = ratio_hi;
    fast_rate = fast;
    P = ratio_hi ? 1280 : 1024;
    B = P / (fast ? 128 : 64);
    foff = 0; boff = 0;
    repeat (5) tick();
    // R8 reset state
    chk(!sync_ok && !word_tick && !bit_tick && !resync_pulse, "R8 reset state",
        {sync_ok, word_tick, bit_tick, resync_pulse}, 0);
    rst_n = 1'b1;
  endtask

  // R8: lock rises two clocks after the second word tick.
  task automatic wait_lock(string req);
    int seen = 0;
    bit done = 1'b0;
    for (int i = 0; i < 6 * P && !done; i++) begin
      tick();
      if (word_tick) begin
        seen++;
        if (seen == 1) chk(fph == 2, "R1 word tick phase", fph, 2);
        if (seen == 2) begin
          chk(!sync_ok, req, sync_ok, 0);
          tick();
          chk(!sync_ok, req, sync_ok, 0);
          tick();
          chk(sync_ok, req, sync_ok, 1);
          done = 1'b1;
        end
      end
    end
    if (!done) chk(1'b0, req, seen, 2);
  endtask

  task automatic hold_lock(int n, string req);
    bit bad = 1'b0;
    for (int i = 0; i < n; i++) begin
      tick();
      if (!sync_ok || resync_pulse) bad = 1'b1;
    end
    chk(!bad, req, bad, 0);
  endtask

  // R3: nothing before the first word clock rising edge.
  task automatic t_quiet_start();
    fs_stop = 1'b1;
    do_reset(1'b0, 1'b1);
    begin
      int act = 0;
      for (int i = 0; i < 3000; i++) begin
        tick();
        if (word_tick || bit_tick || sync_ok) act++;
      end
      chk(act == 0, "R3 quiet before first rise", act, 0);
    end
    wait_fph(P/2);
    fs_stop = 1'b0;
    wait_lock("R8 lock after first alignment");
  endtask

  // R1, R2: periods and edge phase in one strap combination.
  task automatic t_period(bit ratio_hi, bit fast);
    int last = -1;
    int n = 0;
    do_reset(ratio_hi, fast);
    wait_lock("R8 lock in period test");
    for (int i = 0; i < 3 * P && n < 2; i++) begin
      tick();
      if (word_tick) begin
        chk(fph == 2, "R1 word tick phase", fph, 2);
        if (last >= 0) chk(mc - last == P, "R1 word period", mc - last, P);
        last = mc; n++;
      end
    end
    chk(n == 2, "R1 word ticks seen", n, 2);
    last = -1; n = 0;
    for (int i = 0; i < 8 * B && n < 3; i++) begin
      tick();
      if (bit_tick) begin
        // R3: bit boundary taken from the falling edge (phase B/2), plus 2 clocks
        chk(bph == (B/2 + 2) % B, "R2 R3 bit tick phase", bph, (B/2 + 2) % B);
        if (last >= 0) chk(mc - last == B, "R2 bit period", mc - last, B);
        last = mc; n++;
      end
    end
    chk(n == 3, "R2 bit ticks seen", n, 3);
  endtask

  // R4: word edge 2 early then 1 late stays locked.
  task automatic t_fs_tolerance();
    do_reset(1'b0, 1'b1);
    wait_lock("R8 lock before R4");
    wait_fph(P/4);
    foff = foff + 2;
    hold_lock(3 * P, "R4 word edge 2 early accepted");
    wait_fph(P/4);
    foff = foff + P - 3;
    hold_lock(3 * P, "R4 word edge 1 late accepted");
  endtask

  // R5, R10: word edge 3 early.
  task automatic t_fs_early3();
    do_reset(1'b1, 1'b0);
    wait_lock("R8 lock before R5");
    wait_fph(P/4);
    foff = foff + 3;
    wait_fph(0);
    tick(); tick();
    chk(sync_ok, "R5 lock held in error cycle", sync_ok, 1);
    tick();
    chk(!sync_ok, "R5 lock dropped", sync_ok, 0);
    chk(resync_pulse, "R5 resync pulse", resync_pulse, 1);
    wait_lock("R10 relock after word error");
  endtask

  // R6, R10: missing word edge.
  task automatic t_fs_missing();
    do_reset(1'b0, 1'b0);
    wait_lock("R8 lock before R6");
    wait_fph(P/2);
    fs_stop = 1'b1;
    wait_fph(3);
    chk(sync_ok, "R6 lock held until window close", sync_ok, 1);
    tick();
    chk(!sync_ok, "R6 lock dropped on missing edge", sync_ok, 0);
    chk(resync_pulse, "R6 resync pulse", resync_pulse, 1);
    wait_fph(P/2);
    fs_stop = 1'b0;
    wait_lock("R10 relock after missing edge");
  endtask

  // R7: bit edge windows.
  task automatic t_bit_window();
    do_reset(1'b0, 1'b1);
    wait_lock("R8 lock before R7");
    wait_bph(B - 1);
    boff = boff + 2;
    hold_lock(2 * P, "R7 bit edge 2 early accepted");
    do_reset(1'b0, 1'b1);
    wait_lock("R8 lock before R7 reject");
    wait_bph(B - 1);
    boff = boff + 3;
    wait_bph(B/2);
    tick(); tick();
    chk(sync_ok, "R7 lock held in error cycle", sync_ok, 1);
    tick();
    chk(!sync_ok && resync_pulse, "R7 bit edge 3 early rejected",
        {sync_ok, resync_pulse}, 1);
  endtask

  // R9: soft reset.
  task automatic t_soft();
    do_reset(1'b1, 1'b1);
    wait_lock("R8 lock before R9");
    soft_rst = 1'b1;
    tick();
    soft_rst = 1'b0;
    chk(!sync_ok && !word_tick && !bit_tick && !resync_pulse, "R9 soft reset clears",
        {sync_ok, word_tick, bit_tick, resync_pulse}, 0);
    wait_lock("R9 relock after soft reset");
  endtask

  initial begin
    t_quiet_start();
    t_period(1'b0, 1'b1);
    t_period(1'b0, 1'b0);
    t_period(1'b1, 1'b1);
    t_period(1'b1, 1'b0);
    t_fs_tolerance();
    t_fs_early3();
    t_fs_missing();
    t_bit_window();
    t_soft();
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule